// File: doc/BRIEF.md
# Duty-Cycle Memory Bus Throttle

This block slows a processor by requesting a hold on the memory bus for a programmable share of time. An internal divide-by-eight prescaler advances an 8-bit free-running counter. On every counter step the new counter value is compared with an 8-bit throttle setting, and the registered result drives a bus-hold request.

The throttle setting sits behind a simple write/read port. Only its two most significant bits can be written, which gives four duty levels. The request is produced only while a separate slow-down enable input is high. Honouring the hold is left to the bus arbiter outside this block. Setting the enable is also done elsewhere.

Top module: `bus_throttle_top`

## Requirements
- R1: The prescaler produces one counter step every 8 clock cycles. The first step falls on the 8th rising edge after reset is released. The 8-bit counter wraps from FFh to 00h, so the hold pattern repeats every 2048 cycles.
- R2: While `deturbo_en` is low, `bus_hold_req` is low. It drops on the first rising edge at which `deturbo_en` is sampled low, without waiting for a counter step.
- R3: With `deturbo_en` high, `bus_hold_req` is high exactly while the counter value is greater than or equal to the setting. Over any 2048 consecutive cycles it is high for (256 − setting) × 8 cycles. That is 512 cycles for C0h, 1024 for 80h and 1536 for 40h.
- R4: A write stores bits 7:6 of `cfg_wr_data`. Bits 5:0 of the setting are always 0. `cfg_rd_data` shows the stored setting from the cycle after the write edge onward and is unchanged when no write occurs.
- R5: A setting of 00h with `deturbo_en` high keeps `bus_hold_req` high on every cycle after the first counter step.
- R6: Reset (synchronous, `rst_n` low) clears the prescaler, the counter, the hold output and the setting to zero.
- R7: A written setting is used from the next counter step on, and the write never restarts the counter or the prescaler.
- R8: While `deturbo_en` is high, `bus_hold_req` changes only at counter steps. Every high or low run therefore lasts a multiple of 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the throttle setting |
| cfg_wr_data | input | 8 | Write data; only bits 7:6 are kept |
| cfg_rd_data | output | 8 | Current throttle setting |
| deturbo_en | input | 1 | Slow-down enable; hold is requested only while high |
| bus_hold_req | output | 1 | Registered bus-hold request |

## Verification
The duty function is tried with the settings FFh, 80h, 7Fh and 3Fh, whose masked values are C0h, 80h, 40h and 00h. These give hold counts of 512, 1024, 1536 and 2048 per 2048-cycle window, so a wrong comparison direction, an off-by-one threshold or a lost mask bit each shows up as a distinct count. A vector with the enable low separates gating from comparison. Directed runs time the first step after reset, the interval between hold rises, the width of high runs, and the gap from a hold rise to the next rise when a new setting is written in between. That gap tells a write that restarts the counter apart from one that only moves the threshold.

// File: rtl/throttle_pkg.sv
// Package: shared constants and helpers for the bus throttle.
// Assumes the register width equals the counter width.
package throttle_pkg;

    localparam int DEF_CNT_W   = 8;  // counter and setting width
    localparam int DEF_DIV     = 8;  // prescaler divide ratio (power of two)
    localparam int DEF_WR_BITS = 2;  // writable most significant bits

    // Mask of writable bits: the top wb bits of a w-bit word.
    function automatic logic [31:0] wr_mask(input int w, input int wb);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < w; i++) begin
            if (i >= w - wb) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/throttle_prescaler.sv
// Module: divides the core clock into a one-cycle step pulse every DIV cycles.
// Assumes DIV is a power of two, at least 2.
module throttle_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic step_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    // Free-running modulo-DIV phase count.
    always_ff @(posedge clk) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    assign step_o = (div_q == LAST);

    AST_STEP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o); // R1

endmodule

// File: rtl/throttle_counter.sv
// Module: free-running wrap-around counter advanced by the step pulse.
// Assumes step_i is a single-cycle enable from the prescaler.
module throttle_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_next_o
);
    logic [W-1:0] cnt_q;

    assign cnt_next_o = cnt_q + 1'b1;
    assign cnt_o      = cnt_q;

    // Advance on each step and wrap naturally at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (step_i) cnt_q <= cnt_next_o;
    end

    AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(cnt_q)); // R1
    AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> cnt_q == W'($past(cnt_q) + 1)); // R1

endmodule

// File: rtl/throttle_setting.sv
// Module: throttle setting register; only the top WR_BITS bits are storage.
// Assumes WR_BITS <= W; lower bits are tied to zero.
module throttle_setting #(
    parameter int W       = 8,
    parameter int WR_BITS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] value_o
);
    localparam int LO = W - WR_BITS;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i >= LO) begin : g_rw
            logic bit_q;
            // Store one writable bit.
            always_ff @(posedge clk) begin
                if (!rst_n)       bit_q <= 1'b0;
                else if (wr_en_i) bit_q <= wr_data_i[i];
            end
            assign value_o[i] = bit_q;
        end else begin : g_ro
            assign value_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/throttle_hold.sv
// Module: registered hold decision, updated at counter steps.
// Assumes cnt_next_i is the counter value that becomes current at a step.
module throttle_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         step_i,
    input  logic [W-1:0] cnt_next_i,
    input  logic [W-1:0] setting_i,
    output logic         hold_o
);
    logic hold_q;

    // Clear when disabled, else re-evaluate the threshold on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= 1'b0;
        else if (!en_i)  hold_q <= 1'b0;
        else if (step_i) hold_q <= (cnt_next_i >= setting_i);
    end

    assign hold_o = hold_q;

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !hold_q); // R2
    AST_CHANGE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !step_i) |=> $stable(hold_q)); // R8

endmodule

// File: rtl/bus_throttle_top.sv
// Module: duty-cycle memory bus throttle top level.
// Assumes deturbo_en and the write port are synchronous to clk.
module bus_throttle_top
    import throttle_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int DIV     = DEF_DIV,
    parameter int WR_BITS = DEF_WR_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CNT_W-1:0] cfg_wr_data,
    output logic [CNT_W-1:0] cfg_rd_data,
    input  logic             deturbo_en,
    output logic             bus_hold_req
);
    localparam logic [CNT_W-1:0] MASK = CNT_W'(wr_mask(CNT_W, WR_BITS));

    logic             step;
    logic [CNT_W-1:0] cnt, cnt_next, setting;

    throttle_prescaler #(.DIV(DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .step_o(step)
    );

    throttle_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step_i(step),
        .cnt_o(cnt), .cnt_next_o(cnt_next)
    );

    throttle_setting #(.W(CNT_W), .WR_BITS(WR_BITS)) u_set (
        .clk(clk), .rst_n(rst_n), .wr_en_i(cfg_wr_en),
        .wr_data_i(cfg_wr_data), .value_o(setting)
    );

    throttle_hold #(.W(CNT_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .en_i(deturbo_en), .step_i(step),
        .cnt_next_i(cnt_next), .setting_i(setting), .hold_o(bus_hold_req)
    );

    assign cfg_rd_data = setting;

    AST_HOLD_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && deturbo_en) |=> bus_hold_req == (cnt >= $past(setting))); // R3
    AST_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rd_data == ($past(cfg_wr_data) & MASK)); // R4
    AST_SETTING_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(cfg_rd_data)); // R4

endmodule

// File: tb/bus_throttle_top_tb_top.sv
module bus_throttle_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = '0;
    logic [7:0] cfg_rd_data;
    logic       deturbo_en = 1'b0;
    logic       bus_hold_req;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk; // 50 MHz

    bus_throttle_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .deturbo_en(deturbo_en), .bus_hold_req(bus_hold_req)
    );

    // Vectors: written value, expected readback, enable, hold cycles per 2048.
    localparam int NV = 5;
    localparam logic [7:0] V_WR  [NV] = '{8'hFF, 8'h80, 8'h7F, 8'h3F, 8'hC0};
    localparam logic [7:0] V_RD  [NV] = '{8'hC0, 8'h80, 8'h40, 8'h00, 8'hC0};
    localparam logic       V_EN  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam int         V_HLD [NV] = '{512, 1024, 1536, 2048, 0};

    task automatic tick();
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_set(input logic [7:0] d);
        cfg_wr_en = 1'b1;
        cfg_wr_data = d;
        tick();
        cfg_wr_en = 1'b0;
        cfg_wr_data = 8'h00;
    endtask

    task automatic count_hold(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (bus_hold_req) hi++;
        end
    endtask

    // Wait for a 0->1 edge of the hold; returns cyc at the first high sample.
    task automatic wait_rise(output int at);
        logic prev;
        prev = bus_hold_req;
        at = -1;
        for (int i = 0; i < 4200; i++) begin
            tick();
            if (bus_hold_req && !prev) begin
                at = cyc;
                break;
            end
            prev = bus_hold_req;
        end
    endtask

    task automatic wait_fall(output int at);
        at = -1;
        for (int i = 0; i < 4200; i++) begin
            tick();
            if (!bus_hold_req) begin
                at = cyc;
                break;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int hi, t0, t1, t2;

        // R6: reset state, with enable already high and setting 00h.
        deturbo_en = 1'b1;
        repeat (3) tick();
        check("R6 rd after reset", int'(cfg_rd_data), 0);
        check("R6 hold after reset", int'(bus_hold_req), 0);

        // R1/R5: first step on the 8th edge after release.
        rst_n = 1'b1;
        repeat (7) tick();
        check("R1 no step before 8th edge", int'(bus_hold_req), 0);
        tick();
        check("R1 first step at 8th edge", int'(bus_hold_req), 1);
        count_hold(2048, hi);
        check("R5 setting 00h holds continuously", hi, 2048);

        // R2: drop enable between steps, hold falls at next edge.
        repeat (3) tick();
        deturbo_en = 1'b0;
        tick();
        check("R2 hold drops when disabled", int'(bus_hold_req), 0);

        // Vector table: R3 duty, R4 masking, R2 gating.
        for (int v = 0; v < NV; v++) begin
            deturbo_en = V_EN[v];
            write_set(V_WR[v]);
            check("R4 readback masked", int'(cfg_rd_data), int'(V_RD[v]));
            repeat (16) tick();
            count_hold(2048, hi);
            check(V_EN[v] ? "R3 hold duty" : "R2 hold off when disabled", hi, V_HLD[v]);
        end

        // R4: no write leaves setting unchanged.
        repeat (5) tick();
        check("R4 setting kept without write", int'(cfg_rd_data), 8'hC0);

        // R1/R8: period and run width with setting C0h.
        deturbo_en = 1'b1;
        repeat (16) tick();
        wait_rise(t0);
        wait_fall(t1);
        wait_rise(t2);
        check("R8 high run length", t1 - t0, 512);
        check("R1 wrap period", t2 - t0, 2048);

        // R7: write mid-high-run; next rise at counter 80h, no restart.
        repeat (100) tick();
        write_set(8'h80);
        wait_fall(t1);
        check("R7 fall at wrap unchanged", t1 - t2, 512);
        wait_rise(t0);
        check("R7 next rise at new threshold", t0 - t2, 1536);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule